// File: doc/BRIEF.md
# Dual-Width Cell Memory with Address Unit

This block is the private 1 KB scratch store of one processing cell. It also holds a small file of address pointers that generate its addresses. Each access picks its own width: a single byte, or a 16-bit halfword built from an even/odd byte pair. The same storage serves both views, so a table can be written as halfwords and then read back byte by byte.

An access command selects a pointer and an addressing mode. In direct mode the pointer is used as it is. In indexed mode a caller-supplied offset is added to the pointer, which suits table lookups. The two stepping modes use the pointer and then move it up or down by the access size. A separate load port sets any pointer to a new value. Read data comes out of a register one cycle after the command.

Top module: `cell_mem_agu`

## Requirements
- R1: After reset every pointer holds 0, `rd_data` is 0 and `rd_valid` is 0.
- R2: A read command (`op_valid`=1, `op_write`=0) raises `rd_valid` on the next cycle, and the data appears on `rd_data` in that same cycle. In any cycle without a read result, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R3: A byte read (`op_half`=0) returns the byte at the effective address on `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R4: A halfword read (`op_half`=1) ignores bit 0 of the effective address. It returns the byte at the even address on `rd_data[7:0]` and the byte at the odd address on `rd_data[15:8]`.
- R5: A byte write stores `wr_data[7:0]` at the effective address and leaves every other byte unchanged, including the other byte of the same halfword.
- R6: A halfword write stores `wr_data[7:0]` at the even address and `wr_data[15:8]` at the odd address. Bit 0 of the effective address is ignored.
- R7: Mode 2'b01 (step up) accesses at the pointer, then adds 1 to the pointer for a byte access or 2 for a halfword access, modulo 1024.
- R8: Mode 2'b10 (step down) accesses at the pointer, then subtracts 1 for a byte access or 2 for a halfword access, modulo 1024.
- R9: Mode 2'b11 (indexed) accesses at (pointer + `op_idx`) modulo 1024 and leaves the pointer unchanged.
- R10: Mode 2'b00 (direct) accesses at the pointer and leaves it unchanged.
- R11: `ld_en` writes `ld_addr` into pointer `ld_sel`, taking effect on the next cycle. If a stepping access updates the same pointer in the same cycle, the load wins. The access itself still uses the old pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Access command present this cycle |
| op_write | input | 1 | 1 = write, 0 = read |
| op_half | input | 1 | 1 = halfword access, 0 = byte access |
| op_mode | input | 2 | 00 direct, 01 step up, 10 step down, 11 indexed |
| op_reg | input | 2 | Pointer used by the access |
| op_idx | input | 10 | Offset added in indexed mode |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data present this cycle |
| ld_en | input | 1 | Load a pointer |
| ld_sel | input | 2 | Pointer to load |
| ld_addr | input | 10 | Value to load |

## Verification
The timing rules are:
- A read result is due exactly one clock edge after its command.
- A write or a pointer change becomes visible only to a command issued on a later cycle.
- The write data and the new pointer value are in place one edge after the command that causes them.

The bench drives each command just after a rising edge and advances its reference model at the next edge. It then compares `rd_valid` and `rd_data` one time unit after that edge, every cycle, so idle cycles also check that the output holds. Pointer effects are seen only through later reads, so each stepping, indexed or load case is followed by read commands that expose the address actually used.

// File: rtl/cell_mem_agu.sv
module cell_mem_agu #(
  parameter int AW   = 10,
  parameter int BW   = 8,
  parameter int NREG = 4,
  localparam int DW  = 2 * BW,
  localparam int RSW = $clog2(NREG),
  localparam int ROWS = (1 << AW) / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic           op_write,
  input  logic           op_half,
  input  logic [1:0]     op_mode,
  input  logic [RSW-1:0] op_reg,
  input  logic [AW-1:0]  op_idx,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  input  logic           ld_en,
  input  logic [RSW-1:0] ld_sel,
  input  logic [AW-1:0]  ld_addr
);
  localparam logic [1:0] MD_DIR = 2'b00;
  localparam logic [1:0] MD_UP  = 2'b01;
  localparam logic [1:0] MD_DN  = 2'b10;
  localparam logic [1:0] MD_IDX = 2'b11;

  logic [NREG-1:0][AW-1:0] areg;
  logic [BW-1:0] lane_lo [ROWS];
  logic [BW-1:0] lane_hi [ROWS];

  wire [AW-1:0] base   = areg[op_reg];
  wire [AW-1:0] ea_raw = (op_mode == MD_IDX) ? base + op_idx : base;
  wire [AW-1:0] ea     = op_half ? {ea_raw[AW-1:1], 1'b0} : ea_raw;
  wire [AW-2:0] row    = ea[AW-1:1];
  wire [AW-1:0] step   = op_half ? AW'(2) : AW'(1);

  wire do_wr = op_valid & op_write;
  wire do_rd = op_valid & ~op_write;
  wire we_lo = do_wr & (op_half | ~ea[0]);
  wire we_hi = do_wr & (op_half |  ea[0]);
  wire [BW-1:0] hi_wd = op_half ? wr_data[DW-1:BW] : wr_data[BW-1:0];

  wire upd = op_valid & (op_mode == MD_UP || op_mode == MD_DN);
  wire [AW-1:0] nxt = (op_mode == MD_UP) ? base + step : base - step;

  always_ff @(posedge clk) begin
    if (we_lo) lane_lo[row] <= wr_data[BW-1:0];
    if (we_hi) lane_hi[row] <= hi_wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd)
        rd_data <= op_half ? {lane_hi[row], lane_lo[row]}
                           : {{BW{1'b0}}, (ea[0] ? lane_hi[row] : lane_lo[row])};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      areg <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (ld_en && ld_sel == RSW'(i))
          areg[i] <= ld_addr;
        else if (upd && op_reg == RSW'(i))
          areg[i] <= nxt;
      end
    end
  end
endmodule

// File: rtl/cell_mem_agu_chk.sv
module cell_mem_agu_chk #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int NREG = 4,
  parameter int RSW = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    op_valid,
  input logic                    op_write,
  input logic                    op_half,
  input logic [1:0]              op_mode,
  input logic [RSW-1:0]          op_reg,
  input logic [DW-1:0]           rd_data,
  input logic                    rd_valid,
  input logic                    ld_en,
  input logic [RSW-1:0]          ld_sel,
  input logic [AW-1:0]           ld_addr,
  input logic [NREG-1:0][AW-1:0] areg
);
  // R2
  read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_write |=> rd_valid);
  // R2
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && !op_write) |=> !rd_valid);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
  // R3
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_write && !op_half |=> rd_data[DW-1:DW/2] == '0);
  // R9 R10
  ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en && (!op_valid || op_mode == 2'b00 || op_mode == 2'b11) |=> areg == $past(areg));
  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_mode == 2'b01 && !ld_en |=>
      areg[$past(op_reg)] == $past(areg[op_reg]) + ($past(op_half) ? AW'(2) : AW'(1)));
  // R11
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> areg[$past(ld_sel)] == $past(ld_addr));
endmodule

bind cell_mem_agu cell_mem_agu_chk #(.AW(AW), .DW(DW), .NREG(NREG), .RSW(RSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
  .op_half(op_half), .op_mode(op_mode), .op_reg(op_reg), .rd_data(rd_data),
  .rd_valid(rd_valid), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
  .areg(areg)
);

// File: tb/tb_cell_mem_agu.sv
module tb_cell_mem_agu;
  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0, op_write = 0, op_half = 0;
  logic [1:0] op_mode = 0;
  logic [1:0] op_reg = 0;
  logic [9:0] op_idx = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic rd_valid;
  logic ld_en = 0;
  logic [1:0] ld_sel = 0;
  logic [9:0] ld_addr = 0;

  always #10 clk = ~clk;

  cell_mem_agu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_write(op_write),
    .op_half(op_half), .op_mode(op_mode), .op_reg(op_reg), .op_idx(op_idx),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr)
  );

  int mem [1024];
  int regs [4];
  int exp_rd = 0;
  bit exp_vld = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    int ea, st;
    @(posedge clk); #1;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) regs[i] = 0;
      exp_rd = 0; exp_vld = 0;
    end else begin
      exp_vld = op_valid && !op_write;
      if (op_valid) begin
        ea = regs[op_reg];
        if (op_mode == 2'b11) ea = (ea + op_idx) % 1024;
        if (op_half) ea = ea & ~1;
        if (op_write) begin
          mem[ea] = wr_data[7:0];
          if (op_half) mem[ea+1] = wr_data[15:8];
        end else
          exp_rd = op_half ? (mem[ea] | (mem[ea+1] << 8)) : mem[ea];
        st = op_half ? 2 : 1;
        if (op_mode == 2'b01) regs[op_reg] = (regs[op_reg] + st) % 1024;
        if (op_mode == 2'b10) regs[op_reg] = (regs[op_reg] - st + 1024) % 1024;
      end
      if (ld_en) regs[ld_sel] = ld_addr;
    end
    check(tag, rd_valid, exp_vld, "rd_valid");
    check(tag, rd_data, exp_rd, "rd_data");
  endtask

  task automatic acc(input bit w, input bit h, input int m, input int r, input int idx,
                     input int wd, input string tag);
    op_valid = 1; op_write = w; op_half = h; op_mode = m[1:0]; op_reg = r[1:0];
    op_idx = idx[9:0]; wr_data = wd[15:0];
    tick(tag);
    op_valid = 0; ld_en = 0;
  endtask

  task automatic load(input int r, input int a, input string tag);
    ld_en = 1; ld_sel = r[1:0]; ld_addr = a[9:0];
    tick(tag);
    ld_en = 0;
  endtask

  task automatic idle(input string tag);
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle("R1"); idle("R1");
    rst_n = 1;
    idle("R1");
    // R1 R6 R7: fill all memory from pointer 0 by halfword step-up, wraps back to 0
    for (int i = 0; i < 512; i++) acc(1, 1, 1, 0, 0, (i * 40503 + 17) & 16'hffff, "R6");
    // R7 R10: pointer 0 returned to 0
    acc(0, 1, 0, 0, 0, 0, "R7");
    acc(0, 0, 0, 0, 0, 0, "R10");
    // R3 R7: byte reads step up from 5
    load(1, 5, "R11");
    for (int i = 0; i < 6; i++) acc(0, 0, 1, 1, 0, 0, "R3");
    // R4: halfword read from odd pointer
    load(2, 9, "R11");
    for (int i = 0; i < 4; i++) acc(0, 1, 1, 2, 0, 0, "R4");
    // R2: outputs hold while idle
    idle("R2"); idle("R2"); idle("R2");
    // R5: byte writes then halfword reads
    load(3, 101, "R11");
    acc(1, 0, 0, 3, 0, 16'hA55A, "R5");
    acc(0, 1, 0, 3, 0, 0, "R5");
    load(3, 200, "R11");
    acc(1, 0, 1, 3, 0, 16'h1234, "R5");
    acc(1, 0, 1, 3, 0, 16'hBEEF, "R5");
    load(3, 200, "R11");
    acc(0, 1, 0, 3, 0, 0, "R5");
    acc(0, 0, 0, 3, 0, 0, "R5");
    // R6: halfword write with odd address
    load(3, 301, "R11");
    acc(1, 1, 0, 3, 0, 16'hC0DE, "R6");
    acc(0, 1, 0, 3, 0, 0, "R6");
    acc(0, 0, 0, 3, 0, 0, "R6");
    // R8: step down wrap from 0, bytes and halfwords
    load(0, 1, "R11");
    for (int i = 0; i < 4; i++) acc(0, 0, 2, 0, 0, 0, "R8");
    load(0, 2, "R11");
    for (int i = 0; i < 4; i++) acc(0, 1, 2, 0, 0, 0, "R8");
    // R9: indexed with wrap, pointer unchanged
    load(1, 1000, "R11");
    acc(0, 0, 3, 1, 50, 0, "R9");
    acc(0, 1, 3, 1, 3, 0, "R9");
    acc(1, 1, 3, 1, 40, 16'h7E81, "R9");
    acc(0, 1, 3, 1, 40, 0, "R9");
    acc(0, 0, 0, 1, 0, 0, "R9");
    // R11: load collides with step on same pointer
    load(2, 40, "R11");
    ld_en = 1; ld_sel = 2; ld_addr = 10'd600;
    acc(0, 0, 1, 2, 0, 0, "R11");
    acc(0, 0, 0, 2, 0, 0, "R11");
    // R11: load to another pointer does not block step
    load(1, 70, "R11");
    ld_en = 1; ld_sel = 3; ld_addr = 10'd9;
    acc(0, 1, 1, 1, 0, 0, "R11");
    acc(0, 1, 0, 1, 0, 0, "R11");
    acc(0, 0, 0, 3, 0, 0, "R11");
    idle("R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule